// File: doc/BRIEF.md
# Programmable Macrocell with Product-Term Steering

This block is one logic cell of a sum-of-products programmable device. It takes five product terms from an AND array that lies outside the block. Configuration inputs give each term a role. A term can feed the OR sum, act as a clock, act as an asynchronous set or reset, act as an output enable, or be left unused. The OR sum passes through an XOR with a polarity bit. The result then goes to a storage element that works as a D flip-flop or a T flip-flop, or is bypassed so that the output is combinational.

The storage element is clocked by one of three global clocks, with either edge polarity, or by the OR of the terms that have the clock role. A global set/reset input and a power-on reset both force the register to a configured preload value. The cell drives three outputs: a pad value gated by the output enable, the output enable itself, and an ungated feedback copy of the cell value for the interconnect.

Top module: `mc_macrocell`

## Requirements
- R1: Term i has a 3-bit role field at `cfg_role_i[3i+2:3i]`. The codes are 0 sum, 1 clock, 2 set, 3 reset, 4 output enable, and 5 to 7 unused. A term with an unused role affects nothing. The sum is the OR of every term whose role is sum, and it is 0 when no term has that role.
- R2: The cell value entering the storage element, or the bypass path, equals the sum XOR `cfg_xor_pol_i`.
- R3: With `cfg_mode_i` = 0 (D), each active clock edge loads the value into the register. Between edges `mc_fb_o` holds the register value.
- R4: With `cfg_mode_i` = 1 (T), each active clock edge inverts the register when the value is 1 and keeps it when the value is 0.
- R5: With `cfg_mode_i` = 2 or 3 (bypass), `mc_fb_o` follows the value combinationally, with no clock edge needed.
- R6: When a set-role or reset-role term is asserted, the register is forced at once, without waiting for a clock edge: set gives 1 and reset gives 0. When set and reset are active together, reset wins, and both the set and the reset override clock edges.
- R7: While `gsr_i` is high, the register is forced asynchronously to `cfg_init_i`.
- R8: While `por_n_i` is low, the register is forced to `cfg_init_i`. Once `por_n_i` is released, that preload value is held until the next event.
- R9: A `cfg_clk_sel_i` value of 0 to 2 selects `gclk_i[sel]`, which is active on its rising edge, or on its falling edge when `cfg_clk_inv_i` = 1. Edges on global clocks that are not selected have no effect. The value 3 selects the OR of the clock-role terms, and with no clock-role term the register is never clocked.
- R10: The output enable is `goe_i` when `cfg_oe_src_i` = 0. When `cfg_oe_src_i` = 1 it is the OR of the enable-role terms, which is 0 if there are none. `mc_out_o` is the value when the enable is 1 and 0 otherwise, while `mc_fb_o` shows the value whatever the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n_i | input | 1 | Power-on reset, active low, loads the preload value |
| pterm_i | input | 5 | Direct product terms |
| gclk_i | input | 3 | Global clocks |
| gsr_i | input | 1 | Global set/reset to the preload value |
| goe_i | input | 1 | Global output enable |
| cfg_role_i | input | 15 | Role field per term, 3 bits each |
| cfg_mode_i | input | 2 | Storage mode: 0 D, 1 T, 2 or 3 bypass |
| cfg_clk_sel_i | input | 2 | Clock source: 0-2 global, 3 product-term clock |
| cfg_clk_inv_i | input | 1 | Use the falling edge of the selected global clock |
| cfg_xor_pol_i | input | 1 | Polarity bit applied to the OR sum |
| cfg_init_i | input | 1 | Preload value for power-on and global set/reset |
| cfg_oe_src_i | input | 1 | Enable source: 0 global, 1 enable-role terms |
| mc_out_o | output | 1 | Pad value, 0 when not enabled |
| mc_oe_o | output | 1 | Output enable |
| mc_fb_o | output | 1 | Ungated feedback value |

## Verification
The bench drives every input 1 ns after a bench clock edge, fires the selected clock source 1 ns later, and compares all three outputs 1 ns after that. It therefore sees a registered result in the same step that issued its edge. Bypass values, enables and asynchronous set, reset and preload effects have no register in their path, so they are due in the same step as the stimulus that caused them. The reference model updates its register only on a modelled edge or on the rising edge of a set or reset condition. Steps where the bench pulses no clock, or pulses a global clock that is not selected, therefore check that the register holds.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

    localparam int ROLE_W = 3;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_SUM   = 3'd0,
        ROLE_CLK   = 3'd1,
        ROLE_SET   = 3'd2,
        ROLE_RST   = 3'd3,
        ROLE_OE    = 3'd4
    } term_role_e;

    localparam logic [1:0] MODE_D = 2'd0;
    localparam logic [1:0] MODE_T = 2'd1;

    typedef struct packed {
        logic q;
    } mc_state_t;

endpackage

// File: rtl/mc_term_steer.sv
`timescale 1ns/1ps
module mc_term_steer
    import mc_pkg::*;
#(
    parameter int NUM_TERMS = 5
) (
    input  logic [NUM_TERMS-1:0]        pterm_i,
    input  logic [ROLE_W*NUM_TERMS-1:0] role_i,
    output logic                        sum_o,
    output logic                        clk_o,
    output logic                        set_o,
    output logic                        rst_o,
    output logic                        oe_o
);

    logic [NUM_TERMS-1:0] sum_m;
    logic [NUM_TERMS-1:0] clk_m;
    logic [NUM_TERMS-1:0] set_m;
    logic [NUM_TERMS-1:0] rst_m;
    logic [NUM_TERMS-1:0] oe_m;

    for (genvar i = 0; i < NUM_TERMS; i++) begin : g_term
        logic [ROLE_W-1:0] role;
        assign role     = role_i[ROLE_W*i +: ROLE_W];
        assign sum_m[i] = (role == ROLE_SUM);
        assign clk_m[i] = (role == ROLE_CLK);
        assign set_m[i] = (role == ROLE_SET);
        assign rst_m[i] = (role == ROLE_RST);
        assign oe_m[i]  = (role == ROLE_OE);
    end

    assign sum_o = |(pterm_i & sum_m);
    assign clk_o = |(pterm_i & clk_m);
    assign set_o = |(pterm_i & set_m);
    assign rst_o = |(pterm_i & rst_m);
    assign oe_o  = |(pterm_i & oe_m);

endmodule

// File: rtl/mc_clk_mux.sv
`timescale 1ns/1ps
module mc_clk_mux #(
    parameter int NUM_GCLK = 3,
    localparam int SEL_W   = $clog2(NUM_GCLK + 1)
) (
    input  logic [NUM_GCLK-1:0] gclk_i,
    input  logic                pt_clk_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                inv_i,
    output logic                clk_o
);

    always_comb begin
        clk_o = pt_clk_i;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (sel_i == SEL_W'(i)) begin
                clk_o = gclk_i[i] ^ inv_i;
            end
        end
    end

endmodule

// File: rtl/mc_storage.sv
`timescale 1ns/1ps
module mc_storage
    import mc_pkg::*;
(
    input  logic       clk_i,
    input  logic       arst_i,
    input  logic       aset_i,
    input  logic [1:0] mode_i,
    input  logic       val_i,
    output logic       q_o
);

    mc_state_t st_d;
    mc_state_t st_q;

    always_comb begin
        st_d = st_q;
        case (mode_i)
            MODE_D:  st_d.q = val_i;
            MODE_T:  st_d.q = st_q.q ^ val_i;
            default: st_d.q = val_i;
        endcase
    end

    always_ff @(posedge clk_i or posedge arst_i or posedge aset_i) begin
        if (arst_i) begin
            st_q.q <= 1'b0;
        end else if (aset_i) begin
            st_q.q <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;

endmodule

// File: rtl/mc_macrocell.sv
`timescale 1ns/1ps
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_TERMS = 5,
    parameter int NUM_GCLK  = 3,
    localparam int SEL_W    = $clog2(NUM_GCLK + 1),
    localparam int CFG_W    = ROLE_W * NUM_TERMS
) (
    input  logic                 por_n_i,
    input  logic [NUM_TERMS-1:0] pterm_i,
    input  logic [NUM_GCLK-1:0]  gclk_i,
    input  logic                 gsr_i,
    input  logic                 goe_i,
    input  logic [CFG_W-1:0]     cfg_role_i,
    input  logic [1:0]           cfg_mode_i,
    input  logic [SEL_W-1:0]     cfg_clk_sel_i,
    input  logic                 cfg_clk_inv_i,
    input  logic                 cfg_xor_pol_i,
    input  logic                 cfg_init_i,
    input  logic                 cfg_oe_src_i,
    output logic                 mc_out_o,
    output logic                 mc_oe_o,
    output logic                 mc_fb_o
);

    logic pt_sum;
    logic pt_clk;
    logic pt_set;
    logic pt_rst;
    logic pt_oe;
    logic reg_clk;
    logic force_init;
    logic rst_any;
    logic set_any;
    logic d_val;
    logic q_state;
    logic cell_val;
    logic oe_sel;

    mc_term_steer #(.NUM_TERMS(NUM_TERMS)) u_steer (
        .pterm_i (pterm_i),
        .role_i  (cfg_role_i),
        .sum_o   (pt_sum),
        .clk_o   (pt_clk),
        .set_o   (pt_set),
        .rst_o   (pt_rst),
        .oe_o    (pt_oe)
    );

    mc_clk_mux #(.NUM_GCLK(NUM_GCLK)) u_clk (
        .gclk_i   (gclk_i),
        .pt_clk_i (pt_clk),
        .sel_i    (cfg_clk_sel_i),
        .inv_i    (cfg_clk_inv_i),
        .clk_o    (reg_clk)
    );

    always_comb begin
        d_val      = pt_sum ^ cfg_xor_pol_i;
        force_init = ~por_n_i | gsr_i;
        rst_any    = pt_rst | (force_init & ~cfg_init_i);
        set_any    = pt_set | (force_init & cfg_init_i);
    end

    mc_storage u_store (
        .clk_i  (reg_clk),
        .arst_i (rst_any),
        .aset_i (set_any),
        .mode_i (cfg_mode_i),
        .val_i  (d_val),
        .q_o    (q_state)
    );

    always_comb begin
        cell_val = cfg_mode_i[1] ? d_val : q_state;
        oe_sel   = cfg_oe_src_i ? pt_oe : goe_i;
        mc_fb_o  = cell_val;
        mc_oe_o  = oe_sel;
        mc_out_o = cell_val & oe_sel;
    end

endmodule

// File: rtl/mc_macrocell_chk.sv
`timescale 1ns/1ps
module mc_macrocell_chk (
    input logic       clk_i,
    input logic       por_n_i,
    input logic       rst_any_i,
    input logic       set_any_i,
    input logic [1:0] mode_i,
    input logic       q_i,
    input logic       val_i
);

    // R3: a D-mode edge with no forcing leaves the value in the register
    a_r3_dff_load: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (mode_i == 2'd0 && !rst_any_i && !set_any_i)
        |=> (rst_any_i || set_any_i || q_i == $past(val_i)));

    // R4: a T-mode edge inverts on a 1 and holds on a 0
    a_r4_tff_toggle: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (mode_i == 2'd1 && !rst_any_i && !set_any_i)
        |=> (rst_any_i || set_any_i || q_i == $past(q_i ^ val_i)));

    // R6: an active reset keeps the register at 0, even while set is also active
    a_r6_reset_wins: assert property (@(posedge clk_i) disable iff (!por_n_i)
        rst_any_i |-> !q_i);

    // R6: a set with no reset keeps the register at 1
    a_r6_set_forces: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (set_any_i && !rst_any_i) |-> q_i);

endmodule

bind mc_macrocell mc_macrocell_chk u_chk (
    .clk_i     (reg_clk),
    .por_n_i   (por_n_i),
    .rst_any_i (rst_any),
    .set_any_i (set_any),
    .mode_i    (cfg_mode_i),
    .q_i       (q_state),
    .val_i     (d_val)
);

// File: tb/tb_mc_macrocell.sv
`timescale 1ns/1ps
module tb_mc_macrocell;

    logic        clk = 1'b0;
    always #2 clk = ~clk;

    logic        por_n = 1'b1;
    logic [4:0]  pterm = '0;
    logic [2:0]  gclk = '0;
    logic        gsr = 1'b0, goe = 1'b1;
    logic [14:0] cfg_role = '0;
    logic [1:0]  cfg_mode = '0, cfg_sel = '0;
    logic        cfg_inv = 1'b0, cfg_xpol = 1'b0, cfg_init = 1'b0, cfg_oesrc = 1'b0;
    logic        mc_out, mc_oe, mc_fb;

    mc_macrocell dut (
        .por_n_i(por_n), .pterm_i(pterm), .gclk_i(gclk), .gsr_i(gsr), .goe_i(goe),
        .cfg_role_i(cfg_role), .cfg_mode_i(cfg_mode), .cfg_clk_sel_i(cfg_sel),
        .cfg_clk_inv_i(cfg_inv), .cfg_xor_pol_i(cfg_xpol), .cfg_init_i(cfg_init),
        .cfg_oe_src_i(cfg_oesrc), .mc_out_o(mc_out), .mc_oe_o(mc_oe), .mc_fb_o(mc_fb)
    );

    // requested inputs, applied inside tick()
    logic        n_por = 1'b0, n_gsr = 1'b0, n_goe = 1'b1;
    logic [4:0]  n_pterm = '0;
    logic [14:0] n_role = '0;
    logic [1:0]  n_mode = '0, n_sel = '0;
    logic        n_inv = 1'b0, n_xpol = 1'b0, n_init = 1'b0, n_oesrc = 1'b0;

    // reference model state
    logic q_m = 1'b0, rst_prev = 1'b0, set_prev = 1'b0;
    int   n_cmp = 0, n_bad = 0;
    logic done = 1'b0;
    logic [15:0] lf = 16'hACE1;

    function automatic logic [4:0] rmask(input logic [14:0] r, input int code);
        logic [4:0] m = '0;
        for (int i = 0; i < 5; i++) m[i] = (int'(r[3*i +: 3]) == code);
        return m;
    endfunction

    function automatic logic [14:0] rv(input int a4, input int a3, input int a2,
                                       input int a1, input int a0);
        return {3'(a4), 3'(a3), 3'(a2), 3'(a1), 3'(a0)};
    endfunction

    function automatic logic val_now();
        return (|(pterm & rmask(cfg_role, 0))) ^ cfg_xpol;
    endfunction

    function automatic logic rst_now();
        return (|(pterm & rmask(cfg_role, 3))) | ((!por_n | gsr) & !cfg_init);
    endfunction

    function automatic logic set_now();
        return (|(pterm & rmask(cfg_role, 2))) | ((!por_n | gsr) & cfg_init);
    endfunction

    task automatic model_async();
        logic r = rst_now();
        logic s = set_now();
        if ((r && !rst_prev) || (s && !set_prev)) q_m = r ? 1'b0 : 1'b1;
        rst_prev = r;
        set_prev = s;
    endtask

    task automatic model_edge(input int src);
        logic hit;
        logic v = val_now();
        if (src < 3) hit = (src == int'(cfg_sel));
        else         hit = (cfg_sel == 2'd3) && (rmask(cfg_role, 1) != 0);
        if (hit) begin
            if (rst_prev)            q_m = 1'b0;
            else if (set_prev)       q_m = 1'b1;
            else if (cfg_mode == 2'd1) q_m = q_m ^ v;
            else                     q_m = v;
        end
    endtask

    task automatic compare(input string req);
        logic v   = (cfg_mode >= 2'd2) ? val_now() : q_m;
        logic oe  = cfg_oesrc ? |(pterm & rmask(cfg_role, 4)) : goe;
        logic [2:0] exp = {v & oe, oe, v};
        n_cmp++;
        if ({mc_out, mc_oe, mc_fb} !== exp) begin
            n_bad++;
            $display("FAIL %s: out/oe/fb actual %b%b%b expected %b%b%b at %0t",
                     req, mc_out, mc_oe, mc_fb, exp[2], exp[1], exp[0], $time);
        end
    endtask

    // src: 0..2 pulse that global clock, 3 raise the clock-role terms, -1 no edge
    task automatic tick(input int src, input string req);
        @(posedge clk);
        #1;
        por_n = n_por; gsr = n_gsr; goe = n_goe; cfg_role = n_role;
        cfg_mode = n_mode; cfg_sel = n_sel; cfg_inv = n_inv; cfg_xpol = n_xpol;
        cfg_init = n_init; cfg_oesrc = n_oesrc;
        gclk  = {3{n_inv}};
        pterm = n_pterm & ~rmask(n_role, 1);
        model_async();
        #1;
        if (src >= 0) begin
            if (src < 3) gclk[src] = ~gclk[src];
            else         pterm = pterm | rmask(n_role, 1);
            model_edge(src);
        end
        #1;
        compare(req);
    endtask

    task automatic lfsr_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        // R8: power-on preload
        tick(0, "R8 preload 0");
        tick(0, "R8 preload 0 held");
        n_init = 1'b1;
        tick(0, "R8 preload 1");
        n_por = 1'b1; n_init = 1'b0;
        tick(-1, "R8 preload kept after release");

        // R3 / R1: D register on gclk0
        n_pterm = 5'b00001; tick(0, "R3 load 1");
        n_pterm = 5'b00000; tick(0, "R3 load 0");
        n_pterm = 5'b10000; tick(0, "R1 any sum term");
        n_pterm = 5'b00000; tick(-1, "R3 hold without edge");
        n_role = rv(5, 7, 0, 0, 0);
        n_pterm = 5'b11000; tick(0, "R1 unused roles ignored");
        n_pterm = 5'b11001; tick(0, "R1 sum term with unused");
        // R2: polarity
        n_role = '0; n_xpol = 1'b1;
        n_pterm = 5'b00000; tick(0, "R2 inverted zero");
        n_pterm = 5'b00100; tick(0, "R2 inverted one");
        for (int k = 0; k < 40; k++) begin
            lfsr_step();
            n_pterm = lf[4:0] & {5{lf[7]}};
            n_xpol  = lf[9];
            tick(0, "R3 random D");
        end

        // R4: T register
        n_mode = 2'd1; n_xpol = 1'b0;
        for (int k = 0; k < 30; k++) begin
            lfsr_step();
            n_pterm = lf[4:0] & {5{lf[6]}};
            tick((k % 5 == 4) ? -1 : 0, "R4 random T");
        end

        // R5: bypass
        n_mode = 2'd2;
        for (int k = 0; k < 20; k++) begin
            lfsr_step();
            n_pterm = lf[4:0] & {5{lf[8]}};
            n_xpol  = lf[3];
            if (k == 10) n_mode = 2'd3;
            tick(-1, "R5 bypass follows");
        end

        // R9: clock sources
        n_mode = 2'd0; n_xpol = 1'b0; n_sel = 2'd1;
        n_pterm = 5'b00001; tick(0, "R9 unselected clock ignored");
        tick(1, "R9 gclk1 rising");
        n_pterm = 5'b00000; tick(2, "R9 gclk2 ignored");
        n_sel = 2'd2; n_inv = 1'b1;
        tick(2, "R9 gclk2 falling edge");
        n_pterm = 5'b00010; tick(2, "R9 gclk2 falling edge load 1");
        n_sel = 2'd3; n_inv = 1'b0; n_role = rv(1, 0, 0, 0, 0);
        n_pterm = 5'b00000; tick(3, "R9 product-term clock");
        n_pterm = 5'b00001; tick(3, "R9 product-term clock load 1");
        n_pterm = 5'b00000; tick(0, "R9 global ignored on term clock");
        n_role = '0; tick(3, "R9 no clock-role term");

        // R6: asynchronous set/reset via terms
        n_sel = 2'd0; n_role = rv(0, 2, 3, 0, 0);
        n_pterm = 5'b01000; tick(0, "R6 set term");
        n_pterm = 5'b00010; tick(0, "R6 release set, D=1");
        n_pterm = 5'b00110; tick(0, "R6 reset term");
        n_pterm = 5'b00000; tick(0, "R6 release reset");
        n_pterm = 5'b01000; tick(-1, "R6 set without edge");
        tick(0, "R6 set held over edge");
        n_pterm = 5'b01100; tick(0, "R6 reset wins");
        n_pterm = 5'b00010; tick(0, "R6 release both");

        // R7: global set/reset
        n_role = '0; n_gsr = 1'b1; n_init = 1'b0;
        n_pterm = 5'b00001; tick(0, "R7 gsr to 0");
        n_init = 1'b1; n_pterm = 5'b00000; tick(0, "R7 gsr to 1");
        n_gsr = 1'b0; n_init = 1'b0; n_pterm = 5'b00000; tick(0, "R7 release gsr");

        // R10: output enable
        n_mode = 2'd2; n_goe = 1'b0; n_pterm = 5'b00001;
        tick(-1, "R10 global enable low");
        n_goe = 1'b1; tick(-1, "R10 global enable high");
        n_oesrc = 1'b1; n_role = rv(4, 0, 0, 0, 0);
        n_pterm = 5'b10001; tick(-1, "R10 term enable high");
        n_pterm = 5'b00001; tick(-1, "R10 term enable low");
        n_role = '0; n_pterm = 5'b10000; tick(-1, "R10 no enable-role term");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule